// File: doc/BRIEF.md
# Dual-Processor Boot Fetch Steering

This block sits between the address buses of two processors and the chip selects of two boot ROMs. When reset ends, each processor is in a boot phase. During that phase every cycle it issues goes to its own home ROM, whatever address it drives. Processor 0 is homed on ROM 0 and processor 1 on ROM 1. A small per-processor counter counts completed ROM cycles. The counter stops at three, and at that point the boot phase ends. From then on the processor's addresses are decoded against fixed ROM windows, so either processor can read either ROM.

Each processor cycle is a request. `cpu_stb` acts as valid and `rom_sel` acts as ready. The processor holds `cpu_stb` and its address until it sees `cpu_ack`, which can only arrive while `rom_sel` is high.

When both processors want the same free ROM in the same cycle, processor 0 is granted and processor 1 sees `cpu_wait`. This is back-pressure: the waiting processor keeps its request steady. A granted cycle keeps its ROM until it is acknowledged. An address that lies outside every enabled window selects no ROM and raises `out_of_range` for that cycle. ROM contents and bus timing are outside this block.

Top module: `boot_fetch_steer`

## Requirements
- R1: Reset clears each processor's boot count. The count rises by one for each cycle that has `cpu_stb`, `rom_sel` and `cpu_ack` all high, and it holds at 3. The boot phase lasts while the count is below 3. A strobed cycle that waits, misses or is not acknowledged does not count.
- R2: In its boot phase, a strobed cycle from processor 0 is routed to ROM 0 (`rom_idx` bit 0 = 0), and one from processor 1 to ROM 1 (`rom_idx` bit 1 = 1). This holds for any address, and `out_of_range` stays low.
- R3: After the boot phase, addresses 0xFE000000 to 0xFE0FFFFF inclusive select ROM 0 (`rom_idx` = 0) for either processor.
- R4: After the boot phase, ROM 1 (`rom_idx` = 1) is selected by one window only. With `alt_win_sel` = 0 the window is 0xFE400000 to 0xFE4FFFFF. With `alt_win_sel` = 1 it is 0xFD000000 to 0xFDFFFFFF. The window that is not selected is treated as out of range.
- R5: After the boot phase, a strobed address outside every enabled window gives `rom_sel` = 0 and `cpu_wait` = 0, and `out_of_range` = 1 in that same cycle.
- R6: If both processors request the same ROM and no cycle on that ROM is still pending, processor 0 receives `rom_sel` and processor 1 receives `cpu_wait` = 1 with `rom_sel` = 0.
- R7: A granted cycle that is not acknowledged keeps its ROM in the following cycles until it is acknowledged. Meanwhile a request for that ROM from the other processor waits, even when the other processor is processor 0.
- R8: Requests to different ROMs are granted to both processors in the same cycle.
- R9: A processor with `cpu_stb` low has `rom_sel`, `cpu_wait` and `out_of_range` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_win_sel | input | 1 | Selects which window decodes to ROM 1 (0: 0xFE4xxxxx, 1: 0xFDxxxxxx) |
| cpu_stb | input | 2 | Per-processor cycle valid; bit i belongs to processor i |
| cpu_addr | input | 2x32 | Per-processor address; hold it while the strobe is high |
| cpu_ack | input | 2 | Per-processor cycle-complete acknowledge |
| rom_sel | output | 2 | Per-processor ROM grant (ready) |
| rom_idx | output | 2 | Per-processor target ROM number; 0 when there is no target |
| cpu_wait | output | 2 | Request has a target ROM but is held off by the other processor |
| out_of_range | output | 2 | Strobed address outside the enabled windows after boot |

## Verification
The assertions assume that a processor raises `cpu_ack` only in a cycle where it holds `rom_sel`, and that it keeps its strobe and address steady while it waits. The bench drives only sequences of that kind: single-cycle acknowledged fetches, stretched cycles that are acknowledged later, and conflicting requests in which the waiting side is never acknowledged. The bench sweeps the window boundaries for each processor and for each `alt_win_sel` setting. It does this after both boot phases are finished, which it ensures by counting acknowledged cycles from reset itself.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  localparam int NCPU = 2;
  localparam int NROM = 2;
  localparam int AW   = 32;

  // True when the address falls inside the aligned window base..base|mask.
  function automatic logic in_window(input logic [AW-1:0] addr,
                                     input logic [AW-1:0] base,
                                     input logic [AW-1:0] mask);
    return (addr & ~mask) == base;
  endfunction
endpackage

// File: rtl/bfs_boot_counter.sv
module bfs_boot_counter #(
  parameter int BOOT_FETCHES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic done_cycle,
  output logic boot
);
  localparam int CW = $clog2(BOOT_FETCHES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(BOOT_FETCHES);

  logic [CW-1:0] cnt;

  assign boot = (cnt < LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (done_cycle && boot)
      cnt <= cnt + 1'b1;
  end

  // R1: a completed cycle during boot advances the count by exactly one
  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done_cycle && boot) |=> (cnt == $past(cnt) + 1'b1));
  // R1: without a completed cycle the count stays put
  p_cnt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !done_cycle |=> $stable(cnt));
  // R1: count never passes the limit
  p_cnt_limit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIMIT);
endmodule

// File: rtl/bfs_window_decode.sv
module bfs_window_decode
  import bfs_pkg::*;
#(
  parameter logic          HOME        = 1'b0,
  parameter logic [AW-1:0] R0_BASE     = 32'hFE00_0000,
  parameter logic [AW-1:0] R0_MASK     = 32'h000F_FFFF,
  parameter logic [AW-1:0] R1_BASE     = 32'hFE40_0000,
  parameter logic [AW-1:0] R1_MASK     = 32'h000F_FFFF,
  parameter logic [AW-1:0] R1_ALT_BASE = 32'hFD00_0000,
  parameter logic [AW-1:0] R1_ALT_MASK = 32'h00FF_FFFF
) (
  input  logic [AW-1:0] addr,
  input  logic          boot,
  input  logic          alt_sel,
  output logic          hit,
  output logic          tgt
);
  logic in_r0, in_r1_main, in_r1_alt, in_r1;

  always_comb begin
    in_r0      = in_window(addr, R0_BASE, R0_MASK);
    in_r1_main = in_window(addr, R1_BASE, R1_MASK);
    in_r1_alt  = in_window(addr, R1_ALT_BASE, R1_ALT_MASK);
    in_r1      = alt_sel ? in_r1_alt : in_r1_main;
    if (boot) begin
      hit = 1'b1;
      tgt = HOME;
    end else if (in_r0) begin
      hit = 1'b1;
      tgt = 1'b0;
    end else if (in_r1) begin
      hit = 1'b1;
      tgt = 1'b1;
    end else begin
      hit = 1'b0;
      tgt = 1'b0;
    end
  end

  // R3/R4: windows never overlap, so at most one decodes at a time
  always_comb begin
    assert (!(in_r0 && in_r1)) else $error("p_disjoint_r4 window overlap");
  end
endmodule

// File: rtl/bfs_rom_arbiter.sv
module bfs_rom_arbiter #(
  parameter int NCPU = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCPU-1:0] req,
  input  logic [NCPU-1:0] ack,
  output logic [NCPU-1:0] gnt
);
  localparam int IDW = (NCPU > 1) ? $clog2(NCPU) : 1;

  logic           lock_vld;
  logic [IDW-1:0] lock_id;
  logic [IDW-1:0] gnt_id;
  logic           found;

  // A pending owner keeps the ROM; otherwise the lowest index wins.
  always_comb begin
    gnt    = '0;
    gnt_id = '0;
    found  = 1'b0;
    if (lock_vld && req[lock_id]) begin
      gnt[lock_id] = 1'b1;
      gnt_id       = lock_id;
      found        = 1'b1;
    end
    for (int i = 0; i < NCPU; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        gnt_id = i[IDW-1:0];
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_vld <= 1'b0;
      lock_id  <= '0;
    end else begin
      lock_vld <= |(gnt & ~ack);
      lock_id  <= gnt_id;
    end
  end

  // R6: one owner per ROM at a time
  p_one_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  // R6: with nothing pending, processor 0 wins a request
  p_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_vld && req[0]) |-> gnt[0]);

  for (genvar g = 0; g < NCPU; g++) begin : g_keep
    // R7: an unacknowledged grant persists while the request stays
    p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt[g] && !ack[g]) |=> (!req[g] || gnt[g]));
  end
endmodule

// File: rtl/boot_fetch_steer.sv
module boot_fetch_steer
  import bfs_pkg::*;
#(
  parameter int BOOT_FETCHES = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alt_win_sel,
  input  logic [NCPU-1:0]          cpu_stb,
  input  logic [NCPU-1:0][AW-1:0]  cpu_addr,
  input  logic [NCPU-1:0]          cpu_ack,
  output logic [NCPU-1:0]          rom_sel,
  output logic [NCPU-1:0]          rom_idx,
  output logic [NCPU-1:0]          cpu_wait,
  output logic [NCPU-1:0]          out_of_range
);
  logic [NCPU-1:0]            boot;
  logic [NCPU-1:0]            hit;
  logic [NCPU-1:0]            tgt;
  logic [NCPU-1:0]            done_cycle;
  logic [NROM-1:0][NCPU-1:0]  req;
  logic [NROM-1:0][NCPU-1:0]  gnt;

  for (genvar g = 0; g < NCPU; g++) begin : g_cpu
    localparam logic HOME_BIT = 1'(g);

    bfs_boot_counter #(.BOOT_FETCHES(BOOT_FETCHES)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .done_cycle (done_cycle[g]),
      .boot       (boot[g])
    );

    bfs_window_decode #(.HOME(HOME_BIT)) u_dec (
      .addr    (cpu_addr[g]),
      .boot    (boot[g]),
      .alt_sel (alt_win_sel),
      .hit     (hit[g]),
      .tgt     (tgt[g])
    );

    // R2: boot-phase cycles land on the home ROM and never miss
    p_boot_home_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_stb[g] && boot[g]) |-> (rom_idx[g] == HOME_BIT && !out_of_range[g]));
    // R5: a miss never selects or waits
    p_miss_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_of_range[g] |-> (!rom_sel[g] && !cpu_wait[g]));
    // R9: idle processor drives nothing
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_stb[g] |-> (!rom_sel[g] && !cpu_wait[g] && !out_of_range[g]));
  end

  for (genvar r = 0; r < NROM; r++) begin : g_rom
    bfs_rom_arbiter #(.NCPU(NCPU)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req[r]),
      .ack   (cpu_ack),
      .gnt   (gnt[r])
    );
  end

  always_comb begin
    for (int r = 0; r < NROM; r++)
      for (int i = 0; i < NCPU; i++)
        req[r][i] = cpu_stb[i] && hit[i] && (tgt[i] == r[0]);
  end

  always_comb begin
    for (int i = 0; i < NCPU; i++) begin
      rom_sel[i] = 1'b0;
      for (int r = 0; r < NROM; r++)
        rom_sel[i] = rom_sel[i] | gnt[r][i];
      rom_idx[i]      = cpu_stb[i] && hit[i] && tgt[i];
      cpu_wait[i]     = cpu_stb[i] && hit[i] && !rom_sel[i];
      out_of_range[i] = cpu_stb[i] && !hit[i];
      done_cycle[i]   = cpu_stb[i] && cpu_ack[i] && rom_sel[i];
    end
  end

  // R6/R8: two selected processors never share a ROM
  p_no_share_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_sel[0] && rom_sel[1] && rom_idx[0] == rom_idx[1]));
endmodule

// File: tb/boot_fetch_steer_tb_top.sv
`timescale 1ns/1ps
module boot_fetch_steer_tb_top;
  logic             clk = 1'b0;
  logic             rst_n;
  logic             alt_win_sel;
  logic [1:0]       cpu_stb;
  logic [1:0][31:0] cpu_addr;
  logic [1:0]       cpu_ack;
  logic [1:0]       rom_sel, rom_idx, cpu_wait, out_of_range;

  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  boot_fetch_steer dut_i (
    .clk(clk), .rst_n(rst_n), .alt_win_sel(alt_win_sel),
    .cpu_stb(cpu_stb), .cpu_addr(cpu_addr), .cpu_ack(cpu_ack),
    .rom_sel(rom_sel), .rom_idx(rom_idx), .cpu_wait(cpu_wait),
    .out_of_range(out_of_range)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one cycle at a falling edge; outputs settle 1 ns later.
  task automatic drive(input logic s0, input logic [31:0] a0, input logic k0,
                       input logic s1, input logic [31:0] a1, input logic k1);
    cpu_stb[0] = s0; cpu_addr[0] = a0; cpu_ack[0] = k0;
    cpu_stb[1] = s1; cpu_addr[1] = a1; cpu_ack[1] = k1;
    #1;
  endtask

  task automatic next_cycle();
    @(negedge clk);
  endtask

  task automatic check_cpu(input string tag, input int c, input logic sel,
                           input logic idx, input logic wt, input logic oor);
    chk({tag, " rom_sel"}, 32'(rom_sel[c]), 32'(sel));
    chk({tag, " rom_idx"}, 32'(rom_idx[c]), 32'(idx));
    chk({tag, " cpu_wait"}, 32'(cpu_wait[c]), 32'(wt));
    chk({tag, " out_of_range"}, 32'(out_of_range[c]), 32'(oor));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Arithmetic window model: returns {hit, idx}.
  function automatic logic [1:0] model(input logic [31:0] a, input logic alt);
    logic r0, r1;
    r0 = (a >= 32'hFE00_0000) && (a <= 32'hFE0F_FFFF);
    if (alt) r1 = (a >= 32'hFD00_0000) && (a <= 32'hFDFF_FFFF);
    else     r1 = (a >= 32'hFE40_0000) && (a <= 32'hFE4F_FFFF);
    return {r0 | r1, r1};
  endfunction

  logic [31:0] sweep [16];

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    sweep = '{32'hFE00_0000, 32'hFE0F_FFFF, 32'hFE10_0000, 32'hFDFF_FFFF,
              32'hFE3F_FFFF, 32'hFE40_0000, 32'hFE4F_FFFF, 32'hFE50_0000,
              32'hFD00_0000, 32'hFCFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF,
              32'hFE08_0000, 32'hFD80_0000, 32'h7E00_0000, 32'hFE40_0001};
    alt_win_sel = 1'b0;
    @(negedge clk);
    do_reset();

    // R9: idle after reset
    drive(0, 32'hFE00_0000, 0, 0, 32'hFE40_0000, 0);
    check_cpu("R9 idle cpu0", 0, 0, 0, 0, 0);
    check_cpu("R9 idle cpu1", 1, 0, 0, 0, 0);
    next_cycle();

    // R1/R2: cpu0 boot, three acked fetches with one stretched cycle
    drive(1, 32'h0000_0000, 1, 0, 0, 0);
    check_cpu("R2 cpu0 boot fetch0", 0, 1, 0, 0, 0);
    next_cycle();
    drive(1, 32'hFE40_0000, 0, 0, 0, 0);
    check_cpu("R2 cpu0 boot stretched", 0, 1, 0, 0, 0);
    next_cycle();
    drive(1, 32'hFE40_0000, 1, 0, 0, 0);
    check_cpu("R2 cpu0 boot fetch1", 0, 1, 0, 0, 0);
    next_cycle();
    drive(1, 32'hFFFF_FFFF, 1, 0, 0, 0);
    check_cpu("R1 cpu0 boot fetch2", 0, 1, 0, 0, 0);
    next_cycle();
    drive(1, 32'h0000_0000, 0, 0, 0, 0);
    check_cpu("R1 cpu0 override over", 0, 0, 0, 0, 1);
    next_cycle();

    // R1/R2: cpu1 boot, a ROM 0 address still steered to ROM 1
    for (int k = 0; k < 3; k++) begin
      drive(0, 0, 0, 1, 32'hFE00_0000, 1);
      check_cpu("R2 cpu1 boot fetch", 1, 1, 1, 0, 0);
      next_cycle();
    end
    drive(0, 0, 0, 1, 32'h1234_5678, 0);
    check_cpu("R1 cpu1 override over", 1, 0, 0, 0, 1);
    next_cycle();

    // R3/R4/R5: window sweep, each cpu alone, both window settings
    for (int c = 0; c < 2; c++) begin
      for (int alt = 0; alt < 2; alt++) begin
        alt_win_sel = alt[0];
        for (int k = 0; k < 16; k++) begin
          logic [1:0] m;
          m = model(sweep[k], alt[0]);
          if (c == 0) drive(1, sweep[k], m[1], 0, 0, 0);
          else        drive(0, 0, 0, 1, sweep[k], m[1]);
          check_cpu($sformatf("R3 R4 R5 cpu%0d alt%0d addr %08h", c, alt, sweep[k]),
                    c, m[1], m[0], 0, !m[1]);
          next_cycle();
        end
      end
    end

    // R6: simultaneous request for free ROM 0
    alt_win_sel = 1'b0;
    drive(1, 32'hFE00_0010, 1, 1, 32'hFE00_0020, 0);
    check_cpu("R6 cpu0 wins", 0, 1, 0, 0, 0);
    check_cpu("R6 cpu1 waits", 1, 0, 0, 1, 0);
    next_cycle();
    drive(0, 0, 0, 1, 32'hFE00_0020, 1);
    check_cpu("R6 cpu1 after release", 1, 1, 0, 0, 0);
    next_cycle();

    // R7: cpu1 holds ROM 1 across an unacked cycle, cpu0 must wait
    drive(0, 0, 0, 1, 32'hFE40_0100, 0);
    check_cpu("R7 cpu1 granted", 1, 1, 1, 0, 0);
    next_cycle();
    drive(1, 32'hFE40_0200, 0, 1, 32'hFE40_0100, 1);
    check_cpu("R7 cpu0 waits on held ROM", 0, 0, 1, 1, 0);
    check_cpu("R7 cpu1 keeps ROM", 1, 1, 1, 0, 0);
    next_cycle();
    drive(1, 32'hFE40_0200, 1, 0, 0, 0);
    check_cpu("R7 cpu0 after release", 0, 1, 1, 0, 0);
    next_cycle();

    // R8: different ROMs in parallel
    alt_win_sel = 1'b1;
    drive(1, 32'hFE00_0000, 1, 1, 32'hFD00_0000, 1);
    check_cpu("R8 cpu0 ROM0", 0, 1, 0, 0, 0);
    check_cpu("R8 cpu1 ROM1", 1, 1, 1, 0, 0);
    next_cycle();
    drive(1, 32'hFD00_0000, 1, 1, 32'hFE00_0000, 1);
    check_cpu("R8 cpu0 ROM1", 0, 1, 1, 0, 0);
    check_cpu("R8 cpu1 ROM0", 1, 1, 0, 0, 0);
    next_cycle();

    // R1: reset restarts the boot phase
    do_reset();
    drive(1, 32'hFD00_0000, 0, 1, 32'h0000_0000, 0);
    check_cpu("R1 cpu0 boot after reset", 0, 1, 0, 0, 0);
    check_cpu("R1 cpu1 boot after reset", 1, 1, 1, 0, 0);
    next_cycle();
    drive(0, 0, 0, 0, 0, 0);
    next_cycle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule